// File: doc/BRIEF.md
# Time-Slot Power Rail Sequencer

This block turns a single active/shutdown request into an ordered switch-on and switch-off of a set of power-rail enable outputs. Each rail has two small slot numbers: one for switching on and one for switching off. When the request goes high, the block counts through shared time slots and raises each rail at the end of its assigned slot. After the last rail comes up, it waits for a coded delay and then releases an active-low system reset. When the request goes low, reset is pulled low at once. The rails then drop, in the order of their switch-off slots.

Slot length is one 8-bit count times a selectable step, plus half a step. Switching on and switching off each have their own count, and both use the same step select. A rail whose two slot numbers are both zero is not sequenced. It follows a software output bit instead. A rail that is zero in only one direction keeps its level during that direction. All timing comes from a 25 µs tick divided down from the clock, and the clock frequency is a parameter. The block reports a two-bit state code and a sticky flag that records shutdown by the request input. The enable outputs themselves give the drive state of each rail.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is applied, and until the first request, all enables are low, `nrst_o` is low, `state_o` is 00 and `cause_o` is 0.
- R2: A slot lasts (code × step + step/2). The step is 250 µs when `step_sel_i` is 0 and 1000 µs when it is 1. The on-slot field of rail i is `up_slot_i[4i+3:4i]`, and a value k from 1 to 15 raises the rail exactly k slot lengths after the clock edge that first samples `act_i` high in the off state. While `nrst_o` is high, sequenced rails do not change.
- R3: On shutdown, the off-slot field `dn_slot_i[4i+3:4i]` = k drops rail i exactly k off-slot lengths after the edge that samples `act_i` low. The off-slot length uses `dn_time_i` and the shared step.
- R4: `nrst_o` rises a delay after the edge on which the highest on-slot rail rises. Codes 0 to 7 give 0.1 × 2^code ms, and codes 8 to 15 give 1 × 2^(code−8) ms.
- R5: In any powered state, `act_i` sampled low makes `nrst_o` low on that same edge.
- R6: A rail whose slot is 0 in only one direction keeps its level through a sequence in that direction.
- R7: A rail whose on-slot and off-slot are both 0 copies its `gpo_i` bit with one clock of latency, in every state.
- R8: `state_o` is 11 exactly while reset is released (active) and 00 otherwise, including during power-up and power-down.
- R9: `cause_o` is set by the first shutdown that `act_i` low causes, and then stays set until reset.
- R10: If `act_i` rises again during power-down, the power-down runs to its last slot, and a new power-up starts on the next edge after that.
- R11: With no rail mapped for power-up, the reset delay starts on the triggering edge. With no rail mapped for power-down, the block returns to off on the edge that samples `act_i` low.
- R12: If `act_i` falls during power-up or during the reset delay, no further rail rises, and power-down starts from the rails that are already up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_i | input | 1 | Active request (1) or shutdown request (0) |
| step_sel_i | input | 1 | Slot step select: 0 gives 250 µs, 1 gives 1000 µs |
| up_time_i | input | 8 | Power-up slot count |
| dn_time_i | input | 8 | Power-down slot count |
| up_slot_i | input | 4*N_RAIL | Power-up slot per rail, 4 bits each |
| dn_slot_i | input | 4*N_RAIL | Power-down slot per rail, 4 bits each |
| rst_dly_i | input | 4 | Reset release delay code |
| gpo_i | input | N_RAIL | Software level for unsequenced rails |
| en_o | output | N_RAIL | Rail enable outputs |
| nrst_o | output | 1 | Active-low system reset |
| state_o | output | 2 | 11 when active, 00 otherwise |
| cause_o | output | 1 | Last shutdown was caused by act_i low |

## Verification
The hardest situations to reach are a request that reverses in the middle of a sequence. The first is a rise of `act_i` while rails are still dropping. The second is a fall while rails are still coming up. In both cases the outcome depends on which rails had already switched when the reversal came. The stimulus reaches these cases by driving `act_i` at fixed cycle counts chosen to land between known slot edges. A behavioural model follows every clock, so every rail is compared on every cycle. The bench also gives some rails a zero slot in only one direction, so that a held level shows up at the enable pins after a full power-down and a partial power-up.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // all durations are counted in ticks of 25 us
  localparam int TICK_HZ = 40000;
  localparam int TW      = 16;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_UP,
    ST_RDLY,
    ST_ON,
    ST_DN
  } seq_state_e;

  // slot length in ticks: code*step + step/2
  function automatic logic [TW-1:0] slot_ticks(input logic [7:0] code, input logic coarse);
    logic [TW-1:0] c;
    c = {{(TW-8){1'b0}}, code};
    if (coarse) return c * TW'(40) + TW'(20);
    else        return c * TW'(10) + TW'(5);
  endfunction

  // reset delay in ticks: 0.1ms*2^k (k<8) or 1ms*2^(k-8)
  function automatic logic [TW-1:0] dly_ticks(input logic [3:0] code);
    logic [TW-1:0] base;
    base = code[3] ? TW'(40) : TW'(4);
    return base << code[2:0];
  endfunction
endpackage

// File: rtl/seq_timebase.sv
module seq_timebase
  import seq_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expire_o
);
  localparam int DIV = (CLK_HZ / TICK_HZ) < 1 ? 1 : (CLK_HZ / TICK_HZ);
  localparam int PW  = $clog2(DIV + 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tick;

  assign tick     = (pre_q == PW'(DIV - 1));
  assign expire_o = tick && (tmr_q == '0);

  always_comb begin
    pre_d = pre_q;
    tmr_d = tmr_q;
    if (load_i) begin
      pre_d = '0;
      tmr_d = load_val_i - TW'(1);
    end else if (tick) begin
      pre_d = '0;
      if (tmr_q != '0) tmr_d = tmr_q - TW'(1);
    end else begin
      pre_d = pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tmr_q <= '0;
    end else begin
      pre_q <= pre_d;
      tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/seq_rail.sv
module seq_rail #(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] up_slot_i,
  input  logic [SLOT_W-1:0] dn_slot_i,
  input  logic              gpo_i,
  input  logic              up_fire_i,
  input  logic              dn_fire_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              en_o
);
  logic en_q, en_d;
  logic unmapped;

  assign unmapped = (up_slot_i == '0) && (dn_slot_i == '0);

  always_comb begin
    en_d = en_q;
    if (unmapped)
      en_d = gpo_i;
    else if (up_fire_i && (up_slot_i != '0) && (up_slot_i == slot_i))
      en_d = 1'b1;
    else if (dn_fire_i && (dn_slot_i != '0) && (dn_slot_i == slot_i))
      en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_i,
  input  logic              expire_i,
  input  logic [SLOT_W-1:0] max_up_i,
  input  logic [SLOT_W-1:0] max_dn_i,
  input  logic [TW-1:0]     up_len_i,
  input  logic [TW-1:0]     dn_len_i,
  input  logic [TW-1:0]     dly_len_i,
  output logic              load_o,
  output logic [TW-1:0]     load_val_o,
  output logic              up_fire_o,
  output logic              dn_fire_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              nrst_o,
  output logic [1:0]        state_o,
  output logic              cause_o
);
  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              nrst_q, nrst_d;
  logic              cause_q, cause_d;

  always_comb begin
    state_d    = state_q;
    slot_d     = slot_q;
    nrst_d     = nrst_q;
    cause_d    = cause_q;
    load_o     = 1'b0;
    load_val_o = up_len_i;
    up_fire_o  = 1'b0;
    dn_fire_o  = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (act_i) begin
          load_o = 1'b1;
          if (max_up_i == '0) begin
            state_d    = ST_RDLY;
            load_val_o = dly_len_i;
          end else begin
            state_d = ST_UP;
            slot_d  = SLOT_W'(1);
          end
        end
      end
      ST_UP, ST_RDLY, ST_ON: begin
        if (!act_i) begin
          nrst_d  = 1'b0;
          cause_d = 1'b1;
          if (max_dn_i == '0) begin
            state_d = ST_OFF;
          end else begin
            state_d    = ST_DN;
            slot_d     = SLOT_W'(1);
            load_o     = 1'b1;
            load_val_o = dn_len_i;
          end
        end else if (state_q == ST_UP && expire_i) begin
          up_fire_o = 1'b1;
          load_o    = 1'b1;
          if (slot_q >= max_up_i) begin
            state_d    = ST_RDLY;
            load_val_o = dly_len_i;
          end else begin
            slot_d = slot_q + SLOT_W'(1);
          end
        end else if (state_q == ST_RDLY && expire_i) begin
          state_d = ST_ON;
          nrst_d  = 1'b1;
        end
      end
      ST_DN: begin
        if (expire_i) begin
          dn_fire_o = 1'b1;
          if (slot_q >= max_dn_i) begin
            state_d = ST_OFF;
          end else begin
            slot_d     = slot_q + SLOT_W'(1);
            load_o     = 1'b1;
            load_val_o = dn_len_i;
          end
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      slot_q  <= '0;
      nrst_q  <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      nrst_q  <= nrst_d;
      cause_q <= cause_d;
    end
  end

  assign slot_o  = slot_q;
  assign nrst_o  = nrst_q;
  assign cause_o = cause_q;
  assign state_o = (state_q == ST_ON) ? 2'b11 : 2'b00;
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import seq_pkg::*;
#(
  parameter int N_RAIL = 12,
  parameter int SLOT_W = 4,
  parameter int CLK_HZ = 250_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     act_i,
  input  logic                     step_sel_i,
  input  logic [7:0]               up_time_i,
  input  logic [7:0]               dn_time_i,
  input  logic [N_RAIL*SLOT_W-1:0] up_slot_i,
  input  logic [N_RAIL*SLOT_W-1:0] dn_slot_i,
  input  logic [3:0]               rst_dly_i,
  input  logic [N_RAIL-1:0]        gpo_i,
  output logic [N_RAIL-1:0]        en_o,
  output logic                     nrst_o,
  output logic [1:0]               state_o,
  output logic                     cause_o
);
  logic [SLOT_W-1:0] max_up, max_dn, slot;
  logic [TW-1:0]     up_len, dn_len, dly_len, load_val;
  logic              load, expire, up_fire, dn_fire;

  assign up_len  = slot_ticks(up_time_i, step_sel_i);
  assign dn_len  = slot_ticks(dn_time_i, step_sel_i);
  assign dly_len = dly_ticks(rst_dly_i);

  always_comb begin
    max_up = '0;
    max_dn = '0;
    for (int i = 0; i < N_RAIL; i++) begin
      if (up_slot_i[i*SLOT_W +: SLOT_W] > max_up) max_up = up_slot_i[i*SLOT_W +: SLOT_W];
      if (dn_slot_i[i*SLOT_W +: SLOT_W] > max_dn) max_dn = dn_slot_i[i*SLOT_W +: SLOT_W];
    end
  end

  seq_timebase #(.CLK_HZ(CLK_HZ)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .expire_o   (expire)
  );

  seq_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (act_i),
    .expire_i   (expire),
    .max_up_i   (max_up),
    .max_dn_i   (max_dn),
    .up_len_i   (up_len),
    .dn_len_i   (dn_len),
    .dly_len_i  (dly_len),
    .load_o     (load),
    .load_val_o (load_val),
    .up_fire_o  (up_fire),
    .dn_fire_o  (dn_fire),
    .slot_o     (slot),
    .nrst_o     (nrst_o),
    .state_o    (state_o),
    .cause_o    (cause_o)
  );

  for (genvar g = 0; g < N_RAIL; g++) begin : g_rail
    seq_rail #(.SLOT_W(SLOT_W)) u_rail (
      .clk       (clk),
      .rst_n     (rst_n),
      .up_slot_i (up_slot_i[g*SLOT_W +: SLOT_W]),
      .dn_slot_i (dn_slot_i[g*SLOT_W +: SLOT_W]),
      .gpo_i     (gpo_i[g]),
      .up_fire_i (up_fire),
      .dn_fire_i (dn_fire),
      .slot_i    (slot),
      .en_o      (en_o[g])
    );
  end
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int N_RAIL = 12,
  parameter int SLOT_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     act_i,
  input logic [N_RAIL*SLOT_W-1:0] up_slot_i,
  input logic [N_RAIL*SLOT_W-1:0] dn_slot_i,
  input logic [N_RAIL-1:0]        en_o,
  input logic                     nrst_o,
  input logic [1:0]               state_o,
  input logic                     cause_o
);
  logic [N_RAIL-1:0] up_mask, seq_mask;

  always_comb begin
    for (int i = 0; i < N_RAIL; i++) begin
      up_mask[i]  = (up_slot_i[i*SLOT_W +: SLOT_W] != '0);
      seq_mask[i] = up_mask[i] || (dn_slot_i[i*SLOT_W +: SLOT_W] != '0);
    end
  end

  AST_PROMPT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> !nrst_o); // R5

  AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00) || (state_o == 2'b11)); // R8

  AST_ACTIVE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    nrst_o == (state_o == 2'b11)); // R8

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cause_o |=> cause_o); // R9

  AST_ALL_UP_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nrst_o) |-> ((en_o & up_mask) == up_mask)); // R4

  AST_HOLD_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (nrst_o && $past(nrst_o)) |-> ((en_o & seq_mask) == ($past(en_o) & seq_mask))); // R2
endmodule

bind rail_sequencer seq_checker #(.N_RAIL(N_RAIL), .SLOT_W(SLOT_W)) u_seq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .act_i     (act_i),
  .up_slot_i (up_slot_i),
  .dn_slot_i (dn_slot_i),
  .en_o      (en_o),
  .nrst_o    (nrst_o),
  .state_o   (state_o),
  .cause_o   (cause_o)
);

// File: tb/test_rail_sequencer.sv
`timescale 1ns/1ps
module test_rail_sequencer;
  localparam int N      = 12;
  localparam int CLK_HZ = 80000;
  localparam int DIV    = 2;   // clocks per 25 us tick at CLK_HZ

  logic          clk = 1'b0;
  logic          rst_n;
  logic          act;
  logic          step_sel;
  logic [7:0]    up_time, dn_time;
  logic [4*N-1:0] up_slot, dn_slot;
  logic [3:0]    rst_dly;
  logic [N-1:0]  gpo;
  logic [N-1:0]  en_o;
  logic          nrst_o;
  logic [1:0]    state_o;
  logic          cause_o;

  always #2 clk = ~clk;

  rail_sequencer #(.N_RAIL(N), .SLOT_W(4), .CLK_HZ(CLK_HZ)) i_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .act_i(act), .step_sel_i(step_sel),
    .up_time_i(up_time), .dn_time_i(dn_time), .up_slot_i(up_slot),
    .dn_slot_i(dn_slot), .rst_dly_i(rst_dly), .gpo_i(gpo),
    .en_o(en_o), .nrst_o(nrst_o), .state_o(state_o), .cause_o(cause_o)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input string what, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_err++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  function automatic int nib(input logic [4*N-1:0] v, input int i);
    return int'(v[4*i +: 4]);
  endfunction

  function automatic int slot_cyc(input int code, input bit coarse);
    int step_us;
    step_us = coarse ? 1000 : 250;
    return ((code * step_us + step_us / 2) / 25) * DIV;
  endfunction

  function automatic int dly_cyc(input int code);
    int us;
    us = (code < 8) ? (100 << code) : (1000 << (code - 8));
    return (us / 25) * DIV;
  endfunction

  // behavioural reference: 0 off, 1 up, 2 delay, 3 active, 4 down
  int           m_st, m_slot, m_rem;
  logic [N-1:0] m_en;
  logic         m_nrst, m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_slot = 0; m_rem = 0; m_en = '0; m_nrst = 1'b0; m_cause = 1'b0;
    end else begin
      int mu, md, sl;
      bit upf, dnf, go_dn;
      mu = 0; md = 0; upf = 0; dnf = 0; go_dn = 0;
      for (int i = 0; i < N; i++) begin
        if (nib(up_slot, i) > mu) mu = nib(up_slot, i);
        if (nib(dn_slot, i) > md) md = nib(dn_slot, i);
      end
      sl = m_slot;
      case (m_st)
        0: if (act) begin
             if (mu == 0) begin m_st = 2; m_rem = dly_cyc(rst_dly); end
             else begin m_st = 1; m_slot = 1; m_rem = slot_cyc(up_time, step_sel); end
           end
        1, 2, 3: begin
          if (!act) go_dn = 1;
          else if (m_st == 1) begin
            if (m_rem == 1) begin
              upf = 1;
              if (m_slot >= mu) begin m_st = 2; m_rem = dly_cyc(rst_dly); end
              else begin m_slot++; m_rem = slot_cyc(up_time, step_sel); end
            end else m_rem--;
          end else if (m_st == 2) begin
            if (m_rem == 1) begin m_st = 3; m_nrst = 1'b1; end
            else m_rem--;
          end
        end
        4: begin
          if (m_rem == 1) begin
            dnf = 1;
            if (m_slot >= md) m_st = 0;
            else begin m_slot++; m_rem = slot_cyc(dn_time, step_sel); end
          end else m_rem--;
        end
        default: m_st = 0;
      endcase
      if (go_dn) begin
        m_nrst = 1'b0; m_cause = 1'b1;
        if (md == 0) m_st = 0;
        else begin m_st = 4; m_slot = 1; m_rem = slot_cyc(dn_time, step_sel); end
      end
      for (int i = 0; i < N; i++) begin
        if (nib(up_slot, i) == 0 && nib(dn_slot, i) == 0) m_en[i] = gpo[i];
        else if (upf && nib(up_slot, i) == sl) m_en[i] = 1'b1;
        else if (dnf && nib(dn_slot, i) == sl) m_en[i] = 1'b0;
      end
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "en_o", int'(en_o), int'(m_en));
      chk(cur_req, "nrst_o", int'(nrst_o), int'(m_nrst));
      chk(cur_req, "state_o", int'(state_o), (m_st == 3) ? 3 : 0);
      chk(cur_req, "cause_o", int'(cause_o), int'(m_cause));
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog %s actual hung expected done", cur_req);
    finish_run();
  end

  task automatic set_slot(input int i, input int u, input int d);
    up_slot[4*i +: 4] = 4'(u);
    dn_slot[4*i +: 4] = 4'(d);
  endtask

  initial begin
    int cnt;
    rst_n = 1'b0; act = 1'b0; step_sel = 1'b0; up_time = 8'd2; dn_time = 8'd0;
    up_slot = '0; dn_slot = '0; rst_dly = 4'd2; gpo = '0;
    // rails with a one-sided zero: 3, 9 (down 0), 10 (up 0); rail 11 is software driven
    set_slot(0, 1, 15); set_slot(1, 3, 1);  set_slot(2, 3, 2); set_slot(3, 5, 0);
    set_slot(4, 2, 4);  set_slot(5, 7, 4);  set_slot(6, 15, 1); set_slot(7, 4, 3);
    set_slot(8, 1, 2);  set_slot(9, 6, 0);  set_slot(10, 0, 5); set_slot(11, 0, 0);
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1", "en_o", int'(en_o), 0);
    chk("R1", "nrst_o", int'(nrst_o), 0);
    chk("R1", "state_o", int'(state_o), 0);
    chk("R1", "cause_o", int'(cause_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: slot 1 rail rises one slot after the trigger edge
    cur_req = "R2";
    act = 1'b1; cnt = 0;
    while (!en_o[0]) begin @(negedge clk); cnt++; end
    chk("R2", "cycles to slot1 rise", cnt, slot_cyc(2, 0) + 1);

    // R4: reset release after the last rail (slot 15)
    cur_req = "R4";
    while (!en_o[6]) @(negedge clk);
    cnt = 0;
    while (!nrst_o) begin @(negedge clk); cnt++; end
    chk("R4", "cycles last rise to release", cnt, dly_cyc(2));
    chk("R8", "state_o active", int'(state_o), 3);
    chk("R6", "up-zero rail held low", int'(en_o[10]), 0);

    // R7: software-driven rail
    cur_req = "R7";
    gpo[11] = 1'b1; @(negedge clk);
    chk("R7", "gpo rail high", int'(en_o[11]), 1);
    gpo[11] = 1'b0; @(negedge clk);
    chk("R7", "gpo rail low", int'(en_o[11]), 0);

    // R3 / R5: shutdown with coarse step
    cur_req = "R3";
    step_sel = 1'b1; dn_time = 8'd1; up_time = 8'd2;
    @(negedge clk);
    act = 1'b0; cnt = 0;
    while (en_o[1]) begin
      @(negedge clk); cnt++;
      if (cnt == 1) chk("R5", "nrst low after act low", int'(nrst_o), 0);
    end
    chk("R3", "cycles to down slot1 fall", cnt, slot_cyc(1, 1) + 1);
    chk("R9", "cause set", int'(cause_o), 1);

    // R10: request returns mid power-down
    cur_req = "R10";
    repeat (300) @(negedge clk);
    act = 1'b1;
    repeat (1500) @(negedge clk);
    chk("R10", "rail0 down (last slot done)", int'(en_o[0]), 0);
    while (!nrst_o) @(negedge clk);
    chk("R10", "active again", int'(state_o), 3);
    chk("R9", "cause still set", int'(cause_o), 1);

    // R6: full power-down leaves down-zero rails high
    cur_req = "R6";
    step_sel = 1'b0; dn_time = 8'd0; up_time = 8'd2;
    @(negedge clk);
    act = 1'b0;
    repeat (200) @(negedge clk);
    chk("R6", "rails after power-down", int'(en_o), 12'h208);

    // R12: request drops during power-up after slot 3
    cur_req = "R12";
    act = 1'b1;
    repeat (175) @(negedge clk);
    act = 1'b0;
    repeat (200) @(negedge clk);
    chk("R12", "rails after aborted power-up", int'(en_o), 12'h208);
    chk("R12", "reset held", int'(nrst_o), 0);

    // R11: nothing mapped; all rails software driven
    cur_req = "R11";
    up_slot = '0; dn_slot = '0; rst_dly = 4'd15;
    gpo = 12'hA5A; @(negedge clk); @(negedge clk);
    chk("R7", "all rails follow gpo", int'(en_o), 12'hA5A);
    gpo = '0;
    act = 1'b1; cnt = 0;
    while (!nrst_o) begin @(negedge clk); cnt++; end
    chk("R11", "release with no up rails", cnt, dly_cyc(15) + 1);
    act = 1'b0; @(negedge clk);
    chk("R11", "off at once", int'(state_o), 0);
    rst_dly = 4'd8;
    act = 1'b1; cnt = 0;
    while (!nrst_o) begin @(negedge clk); cnt++; end
    chk("R4", "delay code 8", cnt, dly_cyc(8) + 1);

    // R2: coarse step, slot 2, count 0
    cur_req = "R2";
    act = 1'b0; repeat (3) @(negedge clk);
    set_slot(0, 2, 0); step_sel = 1'b1; up_time = 8'd0;
    @(negedge clk);
    act = 1'b1; cnt = 0;
    while (!en_o[0]) begin @(negedge clk); cnt++; end
    chk("R2", "coarse slot2 rise", cnt, 2 * slot_cyc(0, 1) + 1);
    while (!nrst_o) @(negedge clk);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule